// File: doc/BRIEF.md
# Byte/Word Bus Width Interface

This block is the pin-side data path of a nonvolatile memory whose data bus can run 16 or 8 bits wide. It samples the chip-enable, output-enable, write-enable, device-reset and width-select pins through two-flop synchronizers, drives per-bit output enables for the tri-state data pins and steers read data from the array, the status register or the identification source onto them. In 8-bit mode the top data pin stops carrying data and becomes the lowest address bit, so one word address plus that pin selects one of the two bytes of a word.

On the write side, a rising write enable while the chip is enabled captures the address and the data pins and hands them to the command logic as a one-cycle strobe, with the internal address and byte-lane enables matching the selected width. The array, the command decoder and the analog levels sit outside the block.

Top module: `byte_word_bus_if`

## Requirements
- R1: With device reset high, chip enable low, output enable low, write enable high and width select high, all 16 bits of `dq_oe_o` are 1 from the second rising clock edge after the pins settle.
- R2: Output enable high, chip enable high or write enable low makes all 16 bits of `dq_oe_o` 0.
- R3: Device reset low makes all bits of `dq_oe_o` 0 and suppresses any write strobe, whatever the other pins do.
- R4: With width select low, `dq_oe_o[15:8]` are 0 and `dq_oe_o[7:0]` follow the read condition of R1.
- R5: In 16-bit mode with source 0 (array), `dq_o` equals `arr_data_i`.
- R6: In 8-bit mode with source 0, `dq_o[7:0]` is `arr_data_i[7:0]` when pin 15 (the low address bit) is 0 and `arr_data_i[15:8]` when it is 1.
- R7: Source 1 puts `stat_i` and source 2 puts `id_i` on `dq_o[7:0]`, source 3 puts 0 there; in 16-bit mode `dq_o[15:8]` is 0 for these sources.
- R8: `rd_addr_o` is `{addr_i, 1'b0}` in 16-bit mode and `{addr_i, dq_i[15]}` in 8-bit mode.
- R9: A rising write enable with chip enable low gives `wr_stb_o` high for exactly one cycle, after the third rising clock edge following the pin change; with chip enable high no strobe follows.
- R10: A 16-bit write presents `wr_data_o = dq_i`, `wr_be_o = 2'b11` (bit 1 upper byte, bit 0 lower byte) and `wr_addr_o = {addr_i, 1'b0}`.
- R11: An 8-bit write presents `wr_data_o = {dq_i[7:0], dq_i[7:0]}`, `wr_be_o = 2'b10` when pin 15 is 1 and `2'b01` when it is 0, and `wr_addr_o = {addr_i, dq_i[15]}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| dev_rst_ni | input | 1 | Device reset pin, active low |
| ce_ni | input | 1 | Chip enable pin, active low |
| oe_ni | input | 1 | Output enable pin, active low |
| we_ni | input | 1 | Write enable pin, active low |
| wide_i | input | 1 | Width select: 1 = 16-bit, 0 = 8-bit |
| addr_i | input | 18 | Word address pins |
| dq_i | input | 16 | Data pin input sense; bit 15 is the low address bit in 8-bit mode |
| dq_o | output | 16 | Data pin drive value |
| dq_oe_o | output | 16 | Per-pin output enable |
| rd_src_i | input | 2 | Read source: 0 array, 1 status, 2 identification, 3 none |
| arr_data_i | input | 16 | Array read word |
| stat_i | input | 8 | Status byte |
| id_i | input | 8 | Identification byte |
| rd_addr_o | output | 19 | Read address in byte/word form |
| wr_stb_o | output | 1 | One-cycle write capture strobe |
| wr_addr_o | output | 19 | Captured write address |
| wr_data_o | output | 16 | Captured write data |
| wr_be_o | output | 2 | Captured byte-lane enables |

## Verification
A stale synchronizer stage shows up as output enables that switch one cycle early or late, so the bench samples a fixed three edges after each pin change and catches a wrong latency at once. A wrong width state is visible in the same cycle as enabled upper pins or a wrong byte on the low pins, and a broken edge detector shows as a missing, doubled or spurious `wr_stb_o` within the four cycles after the write-enable edge. Byte-lane mistakes appear directly on `wr_be_o` and `wr_data_o` when the strobe fires.

// File: rtl/byte_word_pkg.sv
package byte_word_pkg;
  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_STATUS = 2'd1,
    SRC_IDENT  = 2'd2,
    SRC_NONE   = 2'd3
  } rd_src_e;
endpackage

// File: rtl/bw_sync.sv
module bw_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/bw_rd_steer.sv
module bw_rd_steer
  import byte_word_pkg::*;
#(
  parameter int DW = 16,
  localparam int BW = DW / 2
) (
  input  logic          rd_en_i,
  input  logic          wide_i,
  input  logic          lo_addr_i,
  input  rd_src_e       src_i,
  input  logic [DW-1:0] arr_data_i,
  input  logic [BW-1:0] stat_i,
  input  logic [BW-1:0] id_i,
  output logic [DW-1:0] dq_o,
  output logic [DW-1:0] dq_oe_o
);
  logic [BW-1:0] arr_byte;

  assign arr_byte = lo_addr_i ? arr_data_i[DW-1:BW] : arr_data_i[BW-1:0];

  always_comb begin
    unique case (src_i)
      SRC_ARRAY:  dq_o = wide_i ? arr_data_i : {{BW{1'b0}}, arr_byte};
      SRC_STATUS: dq_o = {{BW{1'b0}}, stat_i};
      SRC_IDENT:  dq_o = {{BW{1'b0}}, id_i};
      default:    dq_o = '0;
    endcase
  end

  // upper lane only in wide mode; pin 15 is an address input otherwise
  assign dq_oe_o = {{BW{rd_en_i & wide_i}}, {BW{rd_en_i}}};
endmodule

// File: rtl/bw_wr_capture.sv
module bw_wr_capture #(
  parameter int WORD_AW = 18,
  parameter int DW      = 16,
  localparam int BW     = DW / 2,
  localparam int NLANE  = DW / BW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             wide_i,
  input  logic [WORD_AW-1:0] addr_i,
  input  logic [DW-1:0]    dq_i,
  output logic             wr_stb_o,
  output logic [WORD_AW:0] wr_addr_o,
  output logic [DW-1:0]    wr_data_o,
  output logic [NLANE-1:0] wr_be_o
);
  logic wide_q;
  logic lo_addr;

  assign lo_addr = dq_i[DW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_stb_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      wr_be_o   <= '0;
      wide_q    <= 1'b1;
    end else begin
      wr_stb_o <= take_i;
      if (take_i) begin
        wide_q <= wide_i;
        if (wide_i) begin
          wr_addr_o <= {addr_i, 1'b0};
          wr_data_o <= dq_i;
          wr_be_o   <= '1;
        end else begin
          wr_addr_o <= {addr_i, lo_addr};
          wr_data_o <= {dq_i[BW-1:0], dq_i[BW-1:0]};
          wr_be_o   <= lo_addr ? 2'b10 : 2'b01;
        end
      end
    end
  end

  // R9
  stb_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o);

  // R11
  byte_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_o && !wide_q) |-> ($countones(wr_be_o) == 1 &&
                               wr_data_o[DW-1:BW] == wr_data_o[BW-1:0]));

  // R10
  word_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_o && wide_q) |-> (&wr_be_o && !wr_addr_o[0]));
endmodule

// File: rtl/byte_word_bus_if.sv
module byte_word_bus_if
  import byte_word_pkg::*;
#(
  parameter int WORD_AW = 18,
  parameter int DW      = 16,
  localparam int BW     = DW / 2,
  localparam int NLANE  = DW / BW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dev_rst_ni,
  input  logic               ce_ni,
  input  logic               oe_ni,
  input  logic               we_ni,
  input  logic               wide_i,
  input  logic [WORD_AW-1:0] addr_i,
  input  logic [DW-1:0]      dq_i,
  output logic [DW-1:0]      dq_o,
  output logic [DW-1:0]      dq_oe_o,
  input  logic [1:0]         rd_src_i,
  input  logic [DW-1:0]      arr_data_i,
  input  logic [BW-1:0]      stat_i,
  input  logic [BW-1:0]      id_i,
  output logic [WORD_AW:0]   rd_addr_o,
  output logic               wr_stb_o,
  output logic [WORD_AW:0]   wr_addr_o,
  output logic [DW-1:0]      wr_data_o,
  output logic [NLANE-1:0]   wr_be_o
);
  logic [4:0] pins_s;
  logic wide_s, dev_s, we_s, oe_s, ce_s;
  logic we_d_q;
  logic rd_en, take;

  // controls idle: wide, device held in reset, strobes inactive
  bw_sync #(.W(5), .RST_VAL(5'b10111)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({wide_i, dev_rst_ni, we_ni, oe_ni, ce_ni}),
    .q_o    (pins_s)
  );
  assign {wide_s, dev_s, we_s, oe_s, ce_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) we_d_q <= 1'b1;
    else         we_d_q <= we_s;
  end

  assign rd_en = dev_s & ~ce_s & ~oe_s & we_s;
  assign take  = dev_s & ~ce_s & we_s & ~we_d_q;

  assign rd_addr_o = {addr_i, wide_s ? 1'b0 : dq_i[DW-1]};

  bw_rd_steer #(.DW(DW)) u_rd (
    .rd_en_i    (rd_en),
    .wide_i     (wide_s),
    .lo_addr_i  (dq_i[DW-1]),
    .src_i      (rd_src_e'(rd_src_i)),
    .arr_data_i (arr_data_i),
    .stat_i     (stat_i),
    .id_i       (id_i),
    .dq_o       (dq_o),
    .dq_oe_o    (dq_oe_o)
  );

  bw_wr_capture #(.WORD_AW(WORD_AW), .DW(DW)) u_wr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (take),
    .wide_i    (wide_s),
    .addr_i    (addr_i),
    .dq_i      (dq_i),
    .wr_stb_o  (wr_stb_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .wr_be_o   (wr_be_o)
  );

  // R3
  dev_reset_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dev_s |-> (dq_oe_o == '0 && !wr_stb_o));

  // R2
  read_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_oe_o != '0) |-> (!ce_s && !oe_s && we_s));

  // R4
  narrow_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide_s |-> (dq_oe_o[DW-1:BW] == '0));
endmodule

// File: tb/byte_word_bus_if_tb_top.sv
`timescale 1ns/1ps
module byte_word_bus_if_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dev_rst_n, ce_n, oe_n, we_n, wide;
  logic [17:0] addr;
  logic [15:0] dq_in;
  logic [15:0] dq_out, dq_oe;
  logic [1:0]  rd_src;
  logic [15:0] arr_data = 16'hC35E;
  logic [7:0]  stat = 8'h80, idv = 8'h2C;
  logic [18:0] rd_addr, wr_addr;
  logic        wr_stb;
  logic [15:0] wr_data;
  logic [1:0]  wr_be;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  byte_word_bus_if dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dev_rst_ni(dev_rst_n), .ce_ni(ce_n),
    .oe_ni(oe_n), .we_ni(we_n), .wide_i(wide), .addr_i(addr), .dq_i(dq_in),
    .dq_o(dq_out), .dq_oe_o(dq_oe), .rd_src_i(rd_src), .arr_data_i(arr_data),
    .stat_i(stat), .id_i(idv), .rd_addr_o(rd_addr), .wr_stb_o(wr_stb),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_be_o(wr_be)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {wide, ce_n, oe_n, we_n, dev_rst_n, src[1:0], a_m1, exp_oe[15:0], exp_dq[15:0]}
  localparam int NV = 11;
  localparam logic [39:0] VEC [NV] = '{
    {8'b1_0_0_1_1_00_0, 16'hFFFF, 16'hC35E},  // R1 R5
    {8'b0_0_0_1_1_00_0, 16'h00FF, 16'h005E},  // R4 R6
    {8'b0_0_0_1_1_00_1, 16'h00FF, 16'h00C3},  // R6
    {8'b1_0_0_1_1_01_0, 16'hFFFF, 16'h0080},  // R7
    {8'b1_0_0_1_1_10_0, 16'hFFFF, 16'h002C},  // R7
    {8'b0_0_0_1_1_10_1, 16'h00FF, 16'h002C},  // R7 R4
    {8'b1_0_1_1_1_00_0, 16'h0000, 16'h0000},  // R2
    {8'b1_1_0_1_1_00_0, 16'h0000, 16'h0000},  // R2
    {8'b1_0_0_0_1_00_0, 16'h0000, 16'h0000},  // R2
    {8'b1_0_0_1_0_00_0, 16'h0000, 16'h0000},  // R3
    {8'b1_0_0_1_1_11_0, 16'hFFFF, 16'h0000}   // R7
  };

  task automatic settle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // drive write pins, then raise write enable and check the strobe cycle
  task automatic do_write(logic w, logic [17:0] a, logic [15:0] d,
                          logic [1:0] be_exp, logic [18:0] a_exp,
                          logic [15:0] d_exp, string req);
    @(negedge clk);
    wide = w; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; addr = a; dq_in = d;
    settle(4);
    @(negedge clk);
    we_n = 1'b1;
    settle(2);
    chk({req, " R9 no early strobe"}, {31'd0, wr_stb}, 32'd0);
    settle(1);
    chk({req, " R9 strobe"}, {31'd0, wr_stb}, 32'd1);
    chk({req, " be"}, {30'd0, wr_be}, {30'd0, be_exp});
    chk({req, " addr"}, {13'd0, wr_addr}, {13'd0, a_exp});
    chk({req, " data"}, {16'd0, wr_data}, {16'd0, d_exp});
    settle(1);
    chk({req, " R9 single"}, {31'd0, wr_stb}, 32'd0);
  endtask

  initial begin
    dev_rst_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; wide = 1'b1;
    addr = '0; dq_in = '0; rd_src = 2'd0;
    #1;
    chk("R3 reset oe", {16'd0, dq_oe}, 32'd0);
    chk("R9 reset stb", {31'd0, wr_stb}, 32'd0);
    settle(3);
    rst_n = 1'b1;
    settle(3);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {wide, ce_n, oe_n, we_n, dev_rst_n, rd_src, dq_in[15]} = VEC[i][39:32];
      settle(3);
      chk($sformatf("vec%0d R1/R2/R3/R4 oe", i), {16'd0, dq_oe}, {16'd0, VEC[i][31:16]});
      chk($sformatf("vec%0d R5/R6/R7 dq", i), {16'd0, dq_out & dq_oe}, {16'd0, VEC[i][15:0]});
    end

    // R1 latency: enables appear at the second edge, not the first
    @(negedge clk);
    wide = 1'b1; ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1; dev_rst_n = 1'b1;
    settle(3);
    @(negedge clk);
    ce_n = 1'b0;
    settle(1);
    chk("R1 one edge", {16'd0, dq_oe}, 32'd0);
    settle(1);
    chk("R1 two edges", {16'd0, dq_oe}, 32'h0000FFFF);

    // R8 read address
    @(negedge clk);
    addr = 18'h2A5C3; dq_in = 16'h8000; wide = 1'b1;
    settle(3);
    chk("R8 wide addr", {13'd0, rd_addr}, {13'd0, 18'h2A5C3, 1'b0});
    @(negedge clk);
    wide = 1'b0;
    settle(3);
    chk("R8 narrow addr", {13'd0, rd_addr}, {13'd0, 18'h2A5C3, 1'b1});

    do_write(1'b1, 18'h12345, 16'hBEEF, 2'b11, {18'h12345, 1'b0}, 16'hBEEF, "R10");
    do_write(1'b0, 18'h0ABCD, 16'h80A7, 2'b10, {18'h0ABCD, 1'b1}, 16'hA7A7, "R11 hi");
    do_write(1'b0, 18'h3FFFF, 16'h0042, 2'b01, {18'h3FFFF, 1'b0}, 16'h4242, "R11 lo");

    // R9: write enable edge with chip disabled
    @(negedge clk);
    wide = 1'b1; ce_n = 1'b1; we_n = 1'b0;
    settle(4);
    @(negedge clk);
    we_n = 1'b1;
    for (int k = 0; k < 5; k++) begin
      settle(1);
      chk("R9 ce high no strobe", {31'd0, wr_stb}, 32'd0);
    end

    // R3: write enable edge under device reset, outputs stay off
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; dev_rst_n = 1'b0; we_n = 1'b0;
    settle(4);
    @(negedge clk);
    we_n = 1'b1;
    for (int k = 0; k < 5; k++) begin
      settle(1);
      chk("R3 no strobe", {31'd0, wr_stb}, 32'd0);
      chk("R3 no drive", {16'd0, dq_oe}, 32'd0);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule